// File: doc/BRIEF.md
# Dual-Clock FIFO with Write-Side Reset Crossing

This block moves data words from a write clock domain to an unrelated read clock domain. Only the writer has a reset input. Asserting that reset flushes every stored word. The reset is also carried into the read domain, where it drives a read-side reset indicator. The reader treats that indicator as "the queue has been wiped; wait".

The writer presents a word with `wrEn` while `wrRdy` is high. `wrRdy` is high again in the first write clock after a reset is released, so the writer never has to wait for the read side to recover. On the read side the oldest word is shown on `rdData` together with `rdRdy` (first-word-fall-through). Asserting `rdEn` while `rdRdy` is high removes that word. Pointers cross between the domains in Gray code through flop synchronizers. The reset crossing asserts at once and deasserts only after synchronization to the read clock. This lets the FIFO survive resets that follow each other closely, at any ratio between the two clocks.

Top module: `cdc_reset_fifo`

## Requirements
- R1: At power-up, with `wrRst` held high, `rdRst` is 1 and `rdRdy` is 0. After `wrRst` is released, `rdRst` falls within SYNC_STAGES+1 read clock edges, and `rdRdy` stays 0 for as long as `rdRst` is 1.
- R2: A `wrRst` pulse lasting one write clock drives `rdRst` to 1 before the next write clock edge. `rdRst` returns to 0 after synchronization.
- R3: In the write clock that immediately follows the release of `wrRst`, `wrRdy` is 1, and a word presented then is accepted.
- R4: Words leave in the order they were written. While `rdRdy` is 1 and `rdEn` is 0, `rdData` holds the oldest word and does not change. `rdData` reads 0 while `rdRdy` is 0.
- R5: Once DEPTH words are stored, `wrRdy` is 0. A `wrEn` presented while `wrRdy` is 0 stores nothing.
- R6: A write reset discards all stored words. After a refill, the first word read is the first word written after the reset.
- R7: If one word is written between two back-to-back write resets, that word is lost. After `rdRst` falls, `rdRdy` stays 0 until a new word is written.
- R8: A stored word raises `rdRdy` within a bounded number of read clocks. A pop on an empty FIFO (`rdEn` while `rdRdy` is 0) changes nothing.
- R9: R1 to R8 hold for equal clocks, for equal clocks 180 degrees apart, for a write clock five times faster than the read clock, and for a read clock five times faster than the write clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wrClk | input | 1 | Write domain clock |
| wrRst | input | 1 | Write domain reset, active high, asynchronous assert; flushes the FIFO |
| wrData | input | DATA_W | Word to store |
| wrEn | input | 1 | Store request, taken when `wrRdy` is 1 |
| wrRdy | output | 1 | Room for a word and not in reset |
| rdClk | input | 1 | Read domain clock |
| rdData | output | DATA_W | Oldest stored word while `rdRdy` is 1, else 0 |
| rdEn | input | 1 | Removes the shown word when `rdRdy` is 1 |
| rdRdy | output | 1 | A word is shown on `rdData` |
| rdRst | output | 1 | Read side held in reset by a write reset |

## Verification
The assertions assume three things about the inputs. `wrEn` and `wrData` change only between write clock edges, and `rdEn` only between read clock edges. `wrRst` is released away from a write clock edge. DEPTH is a power of two. The bench drives every input one time unit after the edge of its own clock. It starts with `wrRst` high before the first edge of either clock, so the pointer properties never see an unreset register. Reset pulses are started and ended only on write-clock timing, at each of the four clock ratios.

// File: rtl/cdc_fifo_pkg.sv
package cdc_fifo_pkg;

  // Strobes from control to datapath.
  typedef struct packed {
    logic push;      // write domain: store wrData at wrAddr
    logic showData;  // read domain: present the head word
  } fifoStrobe_t;

endpackage

// File: rtl/cdc_fifo_sync.sv
module cdc_fifo_sync #(
  parameter int   WIDTH   = 1,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic             clk,
  input  logic             rstAsync,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] qOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stageIn;
    if (s == 0) begin : g_first
      assign stageIn = dIn;
    end else begin : g_next
      assign stageIn = stageQ[s-1];
    end
    always_ff @(posedge clk or posedge rstAsync) begin
      if (rstAsync) stageQ[s] <= {WIDTH{RST_VAL}};
      else          stageQ[s] <= stageIn;
    end
  end

  assign qOut = stageQ[STAGES-1];

endmodule

// File: rtl/cdc_fifo_ctrl.sv
module cdc_fifo_ctrl
  import cdc_fifo_pkg::*;
#(
  parameter  int DEPTH       = 2,
  parameter  int SYNC_STAGES = 2,
  localparam int ADDR_W      = $clog2(DEPTH),
  localparam int PTR_W       = ADDR_W + 1
) (
  input  logic              wrClk,
  input  logic              wrRst,
  input  logic              wrEn,
  output logic              wrRdy,
  output logic [ADDR_W-1:0] wrAddr,
  input  logic              rdClk,
  input  logic              rdEn,
  output logic              rdRdy,
  output logic              rdRst,
  output logic [ADDR_W-1:0] rdAddr,
  output fifoStrobe_t       strobe
);

  function automatic logic [PTR_W-1:0] grayToBin(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // ---------------- write domain ----------------
  logic [PTR_W-1:0] wrBin, wrGray, wrBinNext, rdGraySyncW, rdSyncBin;
  logic             full, pushW;

  assign rdSyncBin = grayToBin(rdGraySyncW);
  assign full      = (wrBin[ADDR_W-1:0] == rdSyncBin[ADDR_W-1:0]) &&
                     (wrBin[PTR_W-1] != rdSyncBin[PTR_W-1]);
  assign wrRdy     = ~full & ~wrRst;
  assign pushW     = wrEn & wrRdy;
  assign wrBinNext = wrBin + PTR_W'(1);

  always_ff @(posedge wrClk or posedge wrRst) begin
    if (wrRst) begin
      wrBin  <= '0;
      wrGray <= '0;
    end else if (pushW) begin
      wrBin  <= wrBinNext;
      wrGray <= wrBinNext ^ (wrBinNext >> 1);
    end
  end

  assign wrAddr = wrBin[ADDR_W-1:0];

  // ---------------- reset crossing ----------------
  logic rdRstQ;
  cdc_fifo_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rstSync (
    .clk(rdClk), .rstAsync(wrRst), .dIn(1'b0), .qOut(rdRstQ)
  );
  assign rdRst = rdRstQ;

  // ---------------- pointer crossings ----------------
  logic [PTR_W-1:0] rdBin, rdGray, rdBinNext, wrGraySyncR, wrSyncBin;

  cdc_fifo_sync #(.WIDTH(PTR_W), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_wrPtrSync (
    .clk(rdClk), .rstAsync(rdRstQ), .dIn(wrGray), .qOut(wrGraySyncR)
  );
  cdc_fifo_sync #(.WIDTH(PTR_W), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rdPtrSync (
    .clk(wrClk), .rstAsync(wrRst), .dIn(rdGray), .qOut(rdGraySyncW)
  );

  // ---------------- read domain ----------------
  logic empty, popR;

  assign wrSyncBin = grayToBin(wrGraySyncR);
  assign empty     = (rdGray == wrGraySyncR);
  assign rdRdy     = ~empty & ~rdRstQ;
  assign popR      = rdEn & rdRdy;
  assign rdBinNext = rdBin + PTR_W'(1);

  always_ff @(posedge rdClk or posedge rdRstQ) begin
    if (rdRstQ) begin
      rdBin  <= '0;
      rdGray <= '0;
    end else if (popR) begin
      rdBin  <= rdBinNext;
      rdGray <= rdBinNext ^ (rdBinNext >> 1);
    end
  end

  assign rdAddr          = rdBin[ADDR_W-1:0];
  assign strobe.push     = pushW;
  assign strobe.showData = rdRdy;

  // ---------------- assertions ----------------
  AST_NO_OVERFLOW: assert property (@(posedge wrClk) disable iff (wrRst)
    (wrBin - rdSyncBin) <= PTR_W'(DEPTH)); // R5
  AST_NO_UNDERFLOW: assert property (@(posedge rdClk) disable iff (rdRstQ)
    (wrSyncBin - rdBin) <= PTR_W'(DEPTH)); // R8
  AST_WR_GRAY_STEP: assert property (@(posedge wrClk) disable iff (wrRst)
    $countones(wrGray ^ $past(wrGray)) <= 1); // R9
  AST_RD_GRAY_STEP: assert property (@(posedge rdClk) disable iff (rdRstQ)
    $countones(rdGray ^ $past(rdGray)) <= 1); // R9

endmodule

// File: rtl/cdc_fifo_data.sv
module cdc_fifo_data
  import cdc_fifo_pkg::*;
#(
  parameter  int DATA_W = 32,
  parameter  int DEPTH  = 2,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              wrClk,
  input  fifoStrobe_t       strobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge wrClk) begin
    if (strobe.push) store[wrAddr] <= wrData;
  end

  assign rdData = strobe.showData ? store[rdAddr] : '0;

endmodule

// File: rtl/cdc_reset_fifo.sv
module cdc_reset_fifo
  import cdc_fifo_pkg::*;
#(
  parameter  int DATA_W      = 32,
  parameter  int DEPTH       = 2,
  parameter  int SYNC_STAGES = 2,
  localparam int ADDR_W      = $clog2(DEPTH)
) (
  input  logic              wrClk,
  input  logic              wrRst,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrEn,
  output logic              wrRdy,
  input  logic              rdClk,
  output logic [DATA_W-1:0] rdData,
  input  logic              rdEn,
  output logic              rdRdy,
  output logic              rdRst
);

  fifoStrobe_t       strobe;
  logic [ADDR_W-1:0] wrAddr, rdAddr;

  cdc_fifo_ctrl #(.DEPTH(DEPTH), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .wrClk(wrClk), .wrRst(wrRst), .wrEn(wrEn), .wrRdy(wrRdy), .wrAddr(wrAddr),
    .rdClk(rdClk), .rdEn(rdEn), .rdRdy(rdRdy), .rdRst(rdRst), .rdAddr(rdAddr),
    .strobe(strobe)
  );

  cdc_fifo_data #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_data (
    .wrClk(wrClk), .strobe(strobe), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData)
  );

  AST_HOLD_HEAD: assert property (@(posedge rdClk) disable iff (rdRst)
    (rdRdy && !rdEn) |=> (rdRdy && $stable(rdData))); // R4

endmodule

// File: tb/cdc_reset_fifo_bench.sv
module cdc_reset_fifo_bench;

  localparam int CLK_PERIOD  = 10;
  localparam int DATA_W      = 32;
  localparam int DEPTH       = 2;
  localparam int SYNC_STAGES = 2;
  localparam int WAIT_LIMIT  = 200;
  localparam int WATCHDOG    = 150000;

  logic wrClk = 1'b0, rdClk = 1'b0;
  int   wrHalf = CLK_PERIOD / 2;
  int   rdHalf = CLK_PERIOD / 2;
  bit   shiftReq = 1'b0;

  logic              wrRst = 1'b0, wrEn = 1'b0, rdEn = 1'b0;
  logic [DATA_W-1:0] wrData = '0;
  logic              wrRdy, rdRdy, rdRst;
  logic [DATA_W-1:0] rdData;

  int checks = 0, fails = 0;
  string ratioName = "power-up";

  cdc_reset_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .SYNC_STAGES(SYNC_STAGES)) u_cdc_reset_fifo (
    .wrClk(wrClk), .wrRst(wrRst), .wrData(wrData), .wrEn(wrEn), .wrRdy(wrRdy),
    .rdClk(rdClk), .rdData(rdData), .rdEn(rdEn), .rdRdy(rdRdy), .rdRst(rdRst)
  );

  initial forever #(wrHalf) wrClk = ~wrClk;
  initial forever begin
    if (shiftReq) begin
      shiftReq = 1'b0;
      #(rdHalf);
    end
    #(rdHalf) rdClk = ~rdClk;
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    checks++;
    fails++;
    $display("FAIL watchdog: actual run still active, expected completion");
    summary();
    $finish;
  end

  task automatic checkEq(string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s [%s]: actual %h expected %h", req, ratioName, act, exp);
    end
  endtask

  task automatic wrTick(); @(posedge wrClk); #1; endtask
  task automatic rdTick(); @(posedge rdClk); #1; endtask

  task automatic writeWord(logic [DATA_W-1:0] d);
    int n = 0;
    while (!wrRdy && n < WAIT_LIMIT) begin wrTick(); n++; end
    if (n >= WAIT_LIMIT) checkEq("R5 wrRdy never returned", 32'(wrRdy), 32'd1);
    wrEn = 1'b1;
    wrData = d;
    wrTick();
    wrEn = 1'b0;
  endtask

  task automatic readWord(output logic [DATA_W-1:0] d);
    int n = 0;
    while (!rdRdy && n < WAIT_LIMIT) begin rdTick(); n++; end
    if (n >= WAIT_LIMIT) checkEq("R8 rdRdy never rose", 32'(rdRdy), 32'd1);
    d = rdData;
    rdEn = 1'b1;
    rdTick();
    rdEn = 1'b0;
  endtask

  task automatic waitRdRstLow();
    int n = 0;
    while (rdRst && n < WAIT_LIMIT) begin rdTick(); n++; end
    checkEq("R2 rdRst deasserts after reset", 32'(rdRst), 32'd0);
  endtask

  // One-write-clock reset pulse; called at a write edge + 1.
  task automatic pulseReset();
    wrRst = 1'b1;
    #1;
    checkEq("R2 rdRst asserted by write reset", 32'(rdRst), 32'd1);
    checkEq("R1 rdRdy low while rdRst", 32'(rdRdy), 32'd0);
    @(posedge wrClk);
    #1;
    wrRst = 1'b0;
    #1;
    checkEq("R3 wrRdy high right after reset release", 32'(wrRdy), 32'd1);
  endtask

  task automatic testPowerUp();
    int n = 0;
    bit rdyLow = 1'b1;
    wrRst = 1'b1;
    repeat (4) wrTick();
    checkEq("R1 rdRst high at power-up", 32'(rdRst), 32'd1);
    checkEq("R1 rdRdy low at power-up", 32'(rdRdy), 32'd0);
    wrRst = 1'b0;
    while (rdRst && n < WAIT_LIMIT) begin
      if (rdRdy) rdyLow = 1'b0;
      rdTick();
      n++;
    end
    checkEq("R1 rdRst release latency within SYNC_STAGES+1", 32'(n <= SYNC_STAGES + 1), 32'd1);
    checkEq("R1 rdRdy stayed low during read reset", 32'(rdyLow), 32'd1);
  endtask

  task automatic testFillOrder(logic [DATA_W-1:0] base);
    logic [DATA_W-1:0] got;
    wrTick();
    for (int i = 0; i < DEPTH; i++) writeWord(base | DATA_W'(i));
    checkEq("R5 wrRdy low when full", 32'(wrRdy), 32'd0);
    wrEn = 1'b1;
    wrData = 32'hDEAD_BEEF;
    repeat (3) wrTick();
    wrEn = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      readWord(got);
      checkEq("R4 read order", got, base | DATA_W'(i));
    end
    repeat (SYNC_STAGES + 4) rdTick();
    checkEq("R5 write while full ignored, FIFO empty after drain", 32'(rdRdy), 32'd0);
    checkEq("R4 rdData zero while not ready", rdData, 32'd0);
    rdEn = 1'b1;
    repeat (2) rdTick();
    rdEn = 1'b0;
    wrTick();
    writeWord(base | 32'h80);
    readWord(got);
    checkEq("R8 pop on empty ignored", got, base | 32'h80);
  endtask

  task automatic testResetRefill(logic [DATA_W-1:0] oldBase, logic [DATA_W-1:0] newBase);
    logic [DATA_W-1:0] got;
    int n = 0;
    wrTick();
    for (int i = 0; i < DEPTH; i++) writeWord(oldBase | DATA_W'(i));
    while (!rdRdy && n < WAIT_LIMIT) begin rdTick(); n++; end
    checkEq("R4 head word before reset", rdData, oldBase);
    wrTick();
    pulseReset();
    for (int i = 0; i < DEPTH; i++) writeWord(newBase | DATA_W'(i));
    waitRdRstLow();
    for (int i = 0; i < DEPTH; i++) begin
      readWord(got);
      checkEq("R6 refill after reset read in order", got, newBase | DATA_W'(i));
    end
    repeat (SYNC_STAGES + 4) rdTick();
    checkEq("R6 no stale word after refill", 32'(rdRdy), 32'd0);
  endtask

  task automatic testResetWriteReset(logic [DATA_W-1:0] fresh);
    logic [DATA_W-1:0] got;
    bit stayedLow = 1'b1;
    wrTick();
    pulseReset();
    writeWord(32'hC3C3_C3C3);
    pulseReset();
    waitRdRstLow();
    for (int i = 0; i < 12; i++) begin
      if (rdRdy) stayedLow = 1'b0;
      rdTick();
    end
    checkEq("R7 word between resets lost", 32'(stayedLow), 32'd1);
    wrTick();
    writeWord(fresh);
    readWord(got);
    checkEq("R7 next word after double reset", got, fresh);
  endtask

  task automatic runRatio(string name, int wh, int rh, bit shift, logic [7:0] tag);
    int failsBefore = fails;
    ratioName = name;
    wrHalf = wh;
    rdHalf = rh;
    shiftReq = shift;
    repeat (4) rdTick();
    repeat (4) wrTick();
    testFillOrder({tag, 24'h5A5A00});
    testResetRefill({tag, 24'h5A5A00}, {tag, 24'hA5A500});
    testResetWriteReset({tag, 24'h3C3C3C});
    checkEq("R9 ratio ran clean", 32'(fails == failsBefore), 32'd1);
  endtask

  initial begin
    #1;
    testPowerUp();
    runRatio("equal clocks", CLK_PERIOD / 2, CLK_PERIOD / 2, 1'b0, 8'h11);
    runRatio("equal clocks 180 deg", CLK_PERIOD / 2, CLK_PERIOD / 2, 1'b1, 8'h22);
    runRatio("write 5x faster", CLK_PERIOD / 2, 5 * CLK_PERIOD / 2, 1'b0, 8'h33);
    runRatio("read 5x faster", 5 * CLK_PERIOD / 2, CLK_PERIOD / 2, 1'b0, 8'h44);
    summary();
    $finish;
  end

endmodule